// File: doc/BRIEF.md
# Display Frame Descriptor Fetcher

This block walks the descriptor chains of a display controller's frame DMA channels once per frame. A pulse on `frame_start` begins a pass. The pass visits the channels in ascending order and skips any channel whose enable bit is low. For each enabled channel the block picks a descriptor address. It uses the channel's next-descriptor pointer, or a pending branch address written by software, which redirects the chain for one frame. It then reads four 32-bit words over a valid/ready memory read port and stores them in the channel's registers.

Once every channel has been fetched, a second sweep checks each enabled channel's frame source address against two memory windows set by parameters. A zero or out-of-window source raises a bus-error pulse that names the channel. A good source raises start-of-frame and end-of-frame pulses when the descriptor's command word asks for them. The pixel transfer itself is not part of this block: the pulses mark where it would begin and end. A register write port sets the next-descriptor and branch registers, and a combinational read port exposes every channel register. Event combining into a CPU interrupt is left to the surrounding logic.

Top module: `disp_desc_fetch`

## Requirements
- R1: A `frame_start` pulse while `busy` is low starts a pass; a pulse while `busy` is high is ignored. Channels are handled in ascending order 0..NCH-1, disabled channels are skipped, and the pass ends with a one-cycle `pass_done` pulse with `busy` low.
- R2: A write with `wr_branch`=0 stores `wr_data` into the channel's next-descriptor register with bits 3:0 forced to zero.
- R3: A write with `wr_branch`=1 stores `wr_data & 0xFFFFFFF3` into the channel's branch register; bit 0 is the branch request, bit 1 the branch-event enable, bits 31:4 the branch descriptor address.
- R4: For an enabled channel with branch bit 0 set, the descriptor is taken from branch bits 31:4 (low nibble zero), bit 0 is cleared, and if bit 1 is set one `ev_bs` pulse is raised for that channel; a disabled channel's branch request stays pending.
- R5: A fetch reads the words at A, A+4, A+8 and A+12 through the valid/ready port (address held while valid and not ready), storing them in order as next-descriptor, source address, frame ID and command.
- R6: A descriptor address A is fetched only if, for one window, BASE <= A and A+16 <= BASE+SIZE; otherwise no memory request is made, the source stays zero and the other channel registers keep their values.
- R7: At the start of every pass the source address of every channel is cleared to zero, enabled or not.
- R8: An enabled channel whose source is zero or lies outside every window (BASE <= S <= BASE+SIZE, bounds inclusive) raises one `ev_ber` pulse with `ev_ch` equal to its channel number, and no start- or end-of-frame pulse.
- R9: An enabled channel with a good source raises `ev_sof` if command bit 22 is set, and then, one cycle later, `ev_eof` if command bit 21 is set; neither is raised when command bit 26 (palette load) is set.
- R10: Event outputs are one-cycle pulses, at most one of them per cycle, each with `ev_ch` naming the channel.
- R11: `rd_data` shows the register chosen by `rd_ch` and `rd_sel` (0 next-descriptor, 1 source, 2 frame ID, 3 command, 4 branch); all registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that begins a descriptor pass |
| ch_enable | input | NCH | Per-channel enable, held for the pass |
| wr_en | input | 1 | Register write strobe |
| wr_branch | input | 1 | 0 selects next-descriptor register, 1 the branch register |
| wr_ch | input | CW | Channel written |
| wr_data | input | 32 | Write data |
| rd_ch | input | CW | Channel read |
| rd_sel | input | 3 | Register read selector |
| rd_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| ev_bs | output | 1 | Branch-start pulse |
| ev_sof | output | 1 | Start-of-frame pulse |
| ev_eof | output | 1 | End-of-frame pulse |
| ev_ber | output | 1 | Bus-error pulse |
| ev_ch | output | CW | Channel of the current pulse |
| busy | output | 1 | Pass in progress |
| pass_done | output | 1 | Pass finished pulse |

## Verification
The hardest situation to reach is a branch request that stays pending across a pass because its channel is disabled. It must not be consumed or raise a pulse until a later pass enables that channel. The bench arms branches on several channels, runs one pass with one of them masked off, and then a second pass with it enabled, and reads the branch register back after each. The window edges are reached the same way. Descriptors are placed exactly at the last legal 16-byte slot and one slot beyond it, and the sources point exactly at a window's inclusive end and one word past it. Memory back-pressure is swept by toggling the ready line on alternate passes.

// File: rtl/disp_desc_pkg.sv
package disp_desc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_REQ,
        ST_WAIT,
        ST_CHECK,
        ST_TAIL
    } fetch_st_e;

    // command word bit positions
    localparam int CMD_EOF_BIT = 21;
    localparam int CMD_SOF_BIT = 22;
    localparam int CMD_PAL_BIT = 26;

    // branch register layout
    localparam int BR_REQ_BIT = 0;
    localparam int BR_EVT_BIT = 1;
    localparam logic [31:0] BR_WR_MASK   = 32'hFFFF_FFF3;
    localparam logic [31:0] DESC_WR_MASK = 32'hFFFF_FFF0;

    // read selector codes
    localparam logic [2:0] SEL_NEXT   = 3'd0;
    localparam logic [2:0] SEL_SRC    = 3'd1;
    localparam logic [2:0] SEL_ID     = 3'd2;
    localparam logic [2:0] SEL_CMD    = 3'd3;
    localparam logic [2:0] SEL_BRANCH = 3'd4;

    localparam int DESC_BYTES = 16;

endpackage

// File: rtl/disp_win_check.sv
// Combinational test that [addr, addr+SPAN] fits inside one of two windows.
module disp_win_check #(
    parameter logic [31:0] W0_BASE = 32'h1000_0000,
    parameter logic [31:0] W0_SIZE = 32'h0010_0000,
    parameter logic [31:0] W1_BASE = 32'h4000_0000,
    parameter logic [31:0] W1_SIZE = 32'h0001_0000,
    parameter int          SPAN    = 16
) (
    input  logic [31:0] addr,
    output logic        ok
);
    localparam int NWIN = 2;
    localparam logic [NWIN-1:0][32:0] WBASE = {{1'b0, W1_BASE}, {1'b0, W0_BASE}};
    localparam logic [NWIN-1:0][32:0] WEND  = {{1'b0, W1_BASE} + {1'b0, W1_SIZE},
                                               {1'b0, W0_BASE} + {1'b0, W0_SIZE}};

    logic [32:0]     last;
    logic [NWIN-1:0] hit;

    assign last = {1'b0, addr} + 33'(SPAN);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit[w] = ({1'b0, addr} >= WBASE[w]) && (last <= WEND[w]);
    end

    assign ok = |hit;
endmodule

// File: rtl/disp_desc_fetch.sv
module disp_desc_fetch
    import disp_desc_pkg::*;
#(
    parameter int          NCH     = 7,
    parameter logic [31:0] W0_BASE = 32'h1000_0000,
    parameter logic [31:0] W0_SIZE = 32'h0010_0000,
    parameter logic [31:0] W1_BASE = 32'h4000_0000,
    parameter logic [31:0] W1_SIZE = 32'h0001_0000,
    localparam int         CW      = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic [NCH-1:0] ch_enable,
    input  logic           wr_en,
    input  logic           wr_branch,
    input  logic [CW-1:0]  wr_ch,
    input  logic [31:0]    wr_data,
    input  logic [CW-1:0]  rd_ch,
    input  logic [2:0]     rd_sel,
    output logic [31:0]    rd_data,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [31:0]    mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [31:0]    mem_rsp_data,
    output logic           ev_bs,
    output logic           ev_sof,
    output logic           ev_eof,
    output logic           ev_ber,
    output logic [CW-1:0]  ev_ch,
    output logic           busy,
    output logic           pass_done
);
    localparam int ENW = 2 ** CW;

    typedef struct packed {
        fetch_st_e             st;
        logic [CW-1:0]         ch;
        logic [1:0]            wi;
        logic [31:0]           faddr;
        logic [NCH-1:0][31:0]  nxt;
        logic [NCH-1:0][31:0]  src;
        logic [NCH-1:0][31:0]  fid;
        logic [NCH-1:0][31:0]  cmd;
        logic [NCH-1:0][31:0]  brn;
        logic                  bs;
        logic                  sof;
        logic                  eof;
        logic                  ber;
        logic [CW-1:0]         evch;
        logic                  done;
    } state_t;

    state_t d, q;

    logic [ENW-1:0] en_ext;
    logic [CW-1:0]  ci;
    logic           at_end;
    logic           cur_en;
    logic [31:0]    sel_addr;
    logic           desc_ok;
    logic           src_win_ok;

    assign en_ext   = {{(ENW - NCH){1'b0}}, ch_enable};
    assign at_end   = (q.ch == CW'(NCH));
    assign ci       = at_end ? '0 : q.ch;
    assign cur_en   = en_ext[q.ch];
    assign sel_addr = q.brn[ci][BR_REQ_BIT] ? (q.brn[ci] & DESC_WR_MASK) : q.nxt[ci];

    disp_win_check #(
        .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
        .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE),
        .SPAN(DESC_BYTES)
    ) i_desc_win (
        .addr(sel_addr),
        .ok  (desc_ok)
    );

    disp_win_check #(
        .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
        .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE),
        .SPAN(0)
    ) i_src_win (
        .addr(q.src[ci]),
        .ok  (src_win_ok)
    );

    always_comb begin
        d      = q;
        d.bs   = 1'b0;
        d.sof  = 1'b0;
        d.eof  = 1'b0;
        d.ber  = 1'b0;
        d.done = 1'b0;

        // software writes; pass updates below take precedence
        if (wr_en && (wr_ch < CW'(NCH))) begin
            if (wr_branch) d.brn[wr_ch] = wr_data & BR_WR_MASK;
            else           d.nxt[wr_ch] = wr_data & DESC_WR_MASK;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    d.src = '0;
                    d.ch  = '0;
                    d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (at_end) begin
                    d.ch = '0;
                    d.st = ST_CHECK;
                end else if (!cur_en) begin
                    d.ch = q.ch + 1'b1;
                end else begin
                    if (q.brn[ci][BR_REQ_BIT]) begin
                        d.brn[ci][BR_REQ_BIT] = 1'b0;
                        if (q.brn[ci][BR_EVT_BIT]) begin
                            d.bs   = 1'b1;
                            d.evch = q.ch;
                        end
                    end
                    if (desc_ok) begin
                        d.faddr = sel_addr;
                        d.wi    = 2'd0;
                        d.st    = ST_REQ;
                    end else begin
                        d.ch = q.ch + 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (q.wi)
                        2'd0: d.nxt[ci] = mem_rsp_data;
                        2'd1: d.src[ci] = mem_rsp_data;
                        2'd2: d.fid[ci] = mem_rsp_data;
                        default: d.cmd[ci] = mem_rsp_data;
                    endcase
                    if (q.wi == 2'd3) begin
                        d.ch = q.ch + 1'b1;
                        d.st = ST_LOAD;
                    end else begin
                        d.wi = q.wi + 2'd1;
                        d.st = ST_REQ;
                    end
                end
            end
            ST_CHECK: begin
                if (at_end) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (!cur_en) begin
                    d.ch = q.ch + 1'b1;
                end else if ((q.src[ci] == 32'd0) || !src_win_ok) begin
                    d.ber  = 1'b1;
                    d.evch = q.ch;
                    d.ch   = q.ch + 1'b1;
                end else if (q.cmd[ci][CMD_PAL_BIT]) begin
                    d.ch = q.ch + 1'b1;
                end else begin
                    if (q.cmd[ci][CMD_SOF_BIT]) begin
                        d.sof  = 1'b1;
                        d.evch = q.ch;
                    end
                    d.st = ST_TAIL;
                end
            end
            default: begin  // ST_TAIL
                if (q.cmd[ci][CMD_EOF_BIT]) begin
                    d.eof  = 1'b1;
                    d.evch = q.ch;
                end
                d.ch = q.ch + 1'b1;
                d.st = ST_CHECK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid = (q.st == ST_REQ);
    assign mem_req_addr  = q.faddr + {28'd0, q.wi, 2'b00};
    assign busy          = (q.st != ST_IDLE);
    assign pass_done     = q.done;
    assign ev_bs         = q.bs;
    assign ev_sof        = q.sof;
    assign ev_eof        = q.eof;
    assign ev_ber        = q.ber;
    assign ev_ch         = q.evch;

    logic [CW-1:0] ri;
    assign ri = (rd_ch < CW'(NCH)) ? rd_ch : '0;

    always_comb begin
        unique case (rd_sel)
            SEL_NEXT:   rd_data = q.nxt[ri];
            SEL_SRC:    rd_data = q.src[ri];
            SEL_ID:     rd_data = q.fid[ri];
            SEL_CMD:    rd_data = q.cmd[ri];
            SEL_BRANCH: rd_data = q.brn[ri];
            default:    rd_data = 32'd0;
        endcase
    end
endmodule

// File: rtl/disp_desc_fetch_chk.sv
module disp_desc_fetch_chk #(
    parameter int NCH = 7,
    parameter int CW  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [31:0]   mem_req_addr,
    input logic          ev_bs,
    input logic          ev_sof,
    input logic          ev_eof,
    input logic          ev_ber,
    input logic [CW-1:0] ev_ch,
    input logic          busy,
    input logic          pass_done
);
    // R5: a request waiting for ready keeps valid and address
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R5: requests are word aligned
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    // R10: at most one event pulse per cycle
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_bs, ev_sof, ev_eof, ev_ber}));

    // R10: the event channel names a real channel
    a_r10_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bs || ev_sof || ev_eof || ev_ber) |-> (ev_ch < CW'(NCH)));

    // R1: no memory traffic and no events outside a pass
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !ev_sof && !ev_eof && !ev_ber && !ev_bs);

    // R1: the end-of-pass pulse coincides with return to idle
    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> !busy);

    // R9: an end-of-frame pulse is never raised in the cycle after a bus error
    a_r9_no_eof_after_ber: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ber |=> !ev_eof);
endmodule

bind disp_desc_fetch disp_desc_fetch_chk #(.NCH(NCH), .CW(CW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .ev_bs        (ev_bs),
    .ev_sof       (ev_sof),
    .ev_eof       (ev_eof),
    .ev_ber       (ev_ber),
    .ev_ch        (ev_ch),
    .busy         (busy),
    .pass_done    (pass_done)
);

// File: tb/test_disp_desc_fetch.sv
`timescale 1ns/1ps
module test_disp_desc_fetch;
    localparam int NCH = 7;
    localparam int CW  = 3;
    localparam logic [31:0] B0 = 32'h1000_0000;
    localparam logic [31:0] S0 = 32'h0010_0000;
    localparam logic [31:0] B1 = 32'h4000_0000;
    localparam logic [31:0] S1 = 32'h0001_0000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0;
    logic [NCH-1:0] ch_enable = '0;
    logic           wr_en = 1'b0, wr_branch = 1'b0;
    logic [CW-1:0]  wr_ch = '0, rd_ch = '0;
    logic [31:0]    wr_data = '0;
    logic [2:0]     rd_sel = '0;
    logic [31:0]    rd_data, mem_req_addr, mem_rsp_data;
    logic           mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic           ev_bs, ev_sof, ev_eof, ev_ber, busy, pass_done;
    logic [CW-1:0]  ev_ch;

    disp_desc_fetch i_disp_desc_fetch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_enable(ch_enable),
        .wr_en(wr_en), .wr_branch(wr_branch), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .ev_bs(ev_bs), .ev_sof(ev_sof),
        .ev_eof(ev_eof), .ev_ber(ev_ber), .ev_ch(ev_ch), .busy(busy),
        .pass_done(pass_done)
    );

    int checks = 0, errors = 0;

    // memory content model
    int          src_mode [8];
    logic [31:0] cmd_tab  [8];
    logic [31:0] desc_tab [8];
    logic [31:0] br_tab   [8];
    logic        stall = 1'b0;

    function automatic int ch_of(logic [31:0] a);
        return int'(((a - B0) >> 8) & 32'h7);
    endfunction

    function automatic logic [31:0] src_val(int c, logic alt);
        case (src_mode[c])
            1: return 32'd0;
            2: return 32'h3000_0000;
            3: return B1 + S1;
            4: return B1 + S1 + 32'd4;
            5: return B0;
            6: return B0 - 32'd4;
            default: return B1 + 32'(c) * 32'h100 + (alt ? 32'h80 : 32'h0);
        endcase
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        logic [31:0] base = a & 32'hFFFF_FFF0;
        case (a[3:2])
            2'd0: return base + 32'h10;
            2'd1: return src_val(ch_of(base), base[7]);
            2'd2: return 32'hC0DE_0000 | (base & 32'h0000_FFF0);
            default: return cmd_tab[ch_of(base)];
        endcase
    endfunction

    function automatic bit in_win(logic [31:0] a, int span);
        logic [32:0] last = {1'b0, a} + 33'(span);
        return (a >= B0 && last <= ({1'b0, B0} + {1'b0, S0})) ||
               (a >= B1 && last <= ({1'b0, B1} + {1'b0, S1}));
    endfunction

    // memory responder
    int req_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            mem_req_ready <= 1'b1;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_word(mem_req_addr);
                req_cnt       <= req_cnt + 1;
            end
            mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
        end
    end

    // event monitor
    int cnt_bs [8], cnt_sof [8], cnt_eof [8], cnt_ber [8];
    int last_bs = -1, last_chk = -1, order_bad = 0, done_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_bs) begin
                cnt_bs[ev_ch]++;
                if (int'(ev_ch) < last_bs) order_bad++;
                last_bs = int'(ev_ch);
            end
            if (ev_sof || ev_eof || ev_ber) begin
                if (ev_sof) cnt_sof[ev_ch]++;
                if (ev_eof) cnt_eof[ev_ch]++;
                if (ev_ber) cnt_ber[ev_ch]++;
                if (int'(ev_ch) < last_chk) order_bad++;
                last_chk = int'(ev_ch);
            end
            if (pass_done) done_cnt++;
        end
    end

    task automatic check32(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic reg_wr(logic br, int c, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_branch = br; wr_ch = CW'(c); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(int c, logic [2:0] sel, output logic [31:0] v);
        rd_ch = CW'(c); rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic set_branch(int c, logic [31:0] v);
        reg_wr(1'b1, c, v);
        br_tab[c] = v & 32'hFFFF_FFF3;
    endtask

    task automatic run_pass(logic [NCH-1:0] en, bit restart, string tag);
        logic [31:0] prev_cmd [NCH], prev_id [NCH], v, a, se, ce;
        int fetched = 0, req0, waitc;
        for (int c = 0; c < NCH; c++) reg_wr(1'b0, c, desc_tab[c]);
        for (int c = 0; c < NCH; c++) begin
            reg_rd(c, 3'd3, prev_cmd[c]);
            reg_rd(c, 3'd2, prev_id[c]);
        end
        for (int c = 0; c < 8; c++) begin
            cnt_bs[c] = 0; cnt_sof[c] = 0; cnt_eof[c] = 0; cnt_ber[c] = 0;
        end
        last_bs = -1; last_chk = -1; order_bad = 0; done_cnt = 0;
        req0 = req_cnt;
        @(negedge clk);
        ch_enable = en; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        waitc = 0;
        while (!pass_done && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (20) @(negedge clk);
        check32($sformatf("R1 %s pass_done count", tag), 32'(done_cnt), 32'd1);
        check32($sformatf("R1 %s busy after pass", tag), {31'd0, busy}, 32'd0);
        check32($sformatf("R1 %s event order", tag), 32'(order_bad), 32'd0);
        for (int c = 0; c < NCH; c++) begin
            bit pend = br_tab[c][0];
            bit fok, berE, sofE, eofE, bsE;
            a   = pend ? (br_tab[c] & 32'hFFFF_FFF0) : (desc_tab[c] & 32'hFFFF_FFF0);
            fok = en[c] && in_win(a, 16);
            if (fok) fetched++;
            se  = fok ? mem_word(a + 32'd4) : 32'd0;
            ce  = fok ? mem_word(a + 32'd12) : prev_cmd[c];
            reg_rd(c, 3'd1, v);
            check32($sformatf("R7 %s ch%0d source", tag, c), v, se);
            reg_rd(c, 3'd0, v);
            check32($sformatf("R6 %s ch%0d next", tag, c), v,
                    fok ? a + 32'h10 : (desc_tab[c] & 32'hFFFF_FFF0));
            reg_rd(c, 3'd2, v);
            check32($sformatf("R5 %s ch%0d id", tag, c), v, fok ? mem_word(a + 32'd8) : prev_id[c]);
            reg_rd(c, 3'd3, v);
            check32($sformatf("R5 %s ch%0d cmd", tag, c), v, ce);
            bsE = en[c] && pend && br_tab[c][1];
            if (en[c] && pend) br_tab[c][0] = 1'b0;
            reg_rd(c, 3'd4, v);
            check32($sformatf("R4 %s ch%0d branch", tag, c), v, br_tab[c]);
            check32($sformatf("R4 %s ch%0d bs events", tag, c), 32'(cnt_bs[c]), 32'(bsE));
            berE = en[c] && (se == 32'd0 || !in_win(se, 0));
            sofE = en[c] && !berE && !ce[26] && ce[22];
            eofE = en[c] && !berE && !ce[26] && ce[21];
            check32($sformatf("R8 %s ch%0d ber events", tag, c), 32'(cnt_ber[c]), 32'(berE));
            check32($sformatf("R9 %s ch%0d sof events", tag, c), 32'(cnt_sof[c]), 32'(sofE));
            check32($sformatf("R9 %s ch%0d eof events", tag, c), 32'(cnt_eof[c]), 32'(eofE));
        end
        check32($sformatf("R5 %s word requests", tag), 32'(req_cnt - req0), 32'(4 * fetched));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < 8; c++) begin
            src_mode[c] = 0;
            cmd_tab[c]  = 32'h0000_0400;
            desc_tab[c] = B0 + 32'(c) * 32'h100;
            br_tab[c]   = 32'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state of every register and output
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 5; s++) begin
                reg_rd(c, 3'(s), v);
                check32($sformatf("R11 reset ch%0d sel%0d", c, s), v, 32'd0);
            end
        check32("R10 reset outputs", {26'd0, ev_bs, ev_sof, ev_eof, ev_ber, busy, mem_req_valid}, 32'd0);

        // R2 / R3: write masks
        reg_wr(1'b0, 3, 32'h1000_0107);
        reg_rd(3, 3'd0, v);
        check32("R2 next-descriptor mask", v, 32'h1000_0100);
        reg_wr(1'b1, 5, 32'hFFFF_FFFF);
        reg_rd(5, 3'd4, v);
        check32("R3 branch mask", v, 32'hFFFF_FFF3);
        reg_wr(1'b1, 5, 32'h0000_0000);
        reg_rd(5, 3'd4, v);
        check32("R3 branch cleared", v, 32'd0);

        // R9 sweep of command flags, with and without back-pressure
        for (int p = 0; p < 8; p++) begin
            stall = p[0];
            for (int c = 0; c < 8; c++) begin
                int f = (c + p) & 7;
                cmd_tab[c] = 32'h0000_0400 | (f[0] ? 32'h0020_0000 : 0)
                                           | (f[1] ? 32'h0040_0000 : 0)
                                           | (f[2] ? 32'h0400_0000 : 0);
            end
            run_pass('1, 1'b0, $sformatf("sweep%0d", p));
        end
        stall = 1'b0;
        for (int c = 0; c < 8; c++) cmd_tab[c] = 32'h0060_0400;

        // R1 enable masks, plus a restart pulse while busy
        run_pass(7'b1010101, 1'b1, "mask55");
        run_pass(7'b0101010, 1'b0, "mask2a");
        run_pass(7'b0000001, 1'b0, "mask01");
        run_pass(7'b1000000, 1'b1, "mask40");
        run_pass(7'b0000000, 1'b0, "mask00");

        // R4 branch: ch6 stays pending while disabled
        set_branch(2, B0 + 32'h280 + 32'd3);
        set_branch(3, B0 + 32'h380 + 32'd1);
        set_branch(6, B0 + 32'h680 + 32'd3);
        run_pass(7'b0111111, 1'b0, "branchA");
        run_pass(7'b1111111, 1'b1, "branchB");

        // R6 descriptor windows and edges
        desc_tab[4] = 32'h2000_0000;
        desc_tab[1] = B0 + S0 - 32'd16;
        desc_tab[5] = B0 + S0;
        desc_tab[0] = B1 + 32'h10;
        desc_tab[6] = B1 + S1 - 32'd16;
        run_pass('1, 1'b0, "window");
        for (int c = 0; c < 8; c++) desc_tab[c] = B0 + 32'(c) * 32'h100;

        // R8 source checks at the window bounds
        for (int c = 0; c < 8; c++) src_mode[c] = c;
        stall = 1'b1;
        run_pass('1, 1'b0, "source");
        for (int c = 0; c < 8; c++) src_mode[c] = (c + 3) % 7;
        stall = 1'b0;
        run_pass('1, 1'b0, "source2");

        finish_run();
    end
endmodule